// File: doc/BRIEF.md
# Reference Divider with Stretched Pulse

This block divides a free-running oscillator clock by a programmable ratio and produces a comparison-rate strobe for a phase/frequency detector. The strobe rests low and rises once per divide period. It stays high for four and a half oscillator cycles. The extra half cycle comes from a register on the falling clock edge, merged with the pulse level that the rising edge produces.

With a ratio of one, the block does not generate pulses. It routes the oscillator clock itself to the output. Ratios of zero and of two to five are too short to hold a 4.5-cycle pulse plus a low gap, so the block treats them as six. The ratio input is sampled only at the terminal count. A new value therefore changes the following period and never cuts the current one short. An output enable, registered on the rising edge, forces the output to a static low while it is deasserted. Reset clears the counter and the enable.

Top module: `ref_divider`

## Requirements
- R1: While `rst` is high, and after it until `out_en` has been sampled high on a rising edge, `ref_out` is low. Reset clears the down-counter to zero.
- R2: For a ratio N of six or more, successive rising edges of `ref_out` are exactly N oscillator cycles apart.
- R3: Each pulse in divide mode starts at a rising edge of `clk_osc` and ends at the falling edge 4.5 cycles later. Within one period the output is high for 9 half-cycles.
- R4: With `div_ratio` equal to 1, `ref_out` follows `clk_osc`. It is high in the clock's high phase and low in its low phase, and no stretched pulse is produced.
- R5: A ratio of 0, 2, 3, 4 or 5 behaves exactly like a ratio of 6.
- R6: A change of `div_ratio` during a period does not alter that period. The new ratio applies from the next terminal count.
- R7: When `out_en` was low at the most recent rising edge, `ref_out` stays low in both divide and pass-through mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock; both edges are used |
| rst | input | 1 | Synchronous active-high reset |
| div_ratio | input | RATIO_W | Divide ratio, sampled at terminal count |
| out_en | input | 1 | Output enable, registered on the rising edge |
| ref_out | output | 1 | Divided strobe, or the oscillator itself at ratio 1 |

## Verification
The checker assumes that reset is held across at least one full oscillator cycle, so the falling-edge register is cleared as well. It also assumes the clock never stops mid-pulse, so the pulse-length history it consults is always filled by real cycles. Ratio and enable may change at any time, since the design samples them only on rising edges. The bench drives every input five nanoseconds after an edge and samples `ref_out` in the middle of each half-cycle. Both clock phases are therefore seen without any race at an edge.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    localparam int unsigned RATIO_W_DEF = 16;
    localparam int unsigned PULSE_WHOLE = 4;   // whole cycles of the rising-edge level
    localparam int unsigned MIN_PULSED  = 6;   // shortest ratio that fits the pulse and a gap

    typedef enum logic {
        MODE_DIVIDE = 1'b0,
        MODE_PASS   = 1'b1
    } rdiv_mode_e;

    typedef struct packed {
        logic       tc;     // terminal count this cycle
        logic       start;  // begin a stretched pulse
        rdiv_mode_e mode;   // mode in force for the current period
    } rdiv_tick_t;

    // ratio actually used: 1 stays 1, short ratios are raised to the minimum
    function automatic int unsigned clamp_ratio(input int unsigned r);
        if (r == 1)
            return 1;
        else if (r < MIN_PULSED)
            return MIN_PULSED;
        else
            return r;
    endfunction

endpackage

// File: rtl/rdiv_counter.sv
module rdiv_counter
    import rdiv_pkg::*;
#(
    parameter int unsigned RATIO_W = RATIO_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio,
    output rdiv_tick_t         tick
);

    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] reload;
    rdiv_mode_e         mode_q;
    logic               at_tc;
    logic               pass_req;

    assign at_tc    = (cnt_q == '0);
    assign pass_req = (ratio == ONE);
    assign reload   = RATIO_W'(clamp_ratio(32'(ratio)) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            mode_q <= MODE_DIVIDE;
        end else if (at_tc) begin
            cnt_q  <= reload;
            mode_q <= pass_req ? MODE_PASS : MODE_DIVIDE;
        end else begin
            cnt_q  <= cnt_q - ONE;
        end
    end

    always_comb begin
        tick.tc    = at_tc;
        tick.start = at_tc && !pass_req;
        tick.mode  = mode_q;
    end

endmodule

// File: rtl/rdiv_stretch.sv
module rdiv_stretch
    import rdiv_pkg::*;
#(
    parameter int unsigned WHOLE = PULSE_WHOLE
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic lvl_r,
    output logic half_f,
    output logic pulse
);

    localparam int unsigned PW_W = $clog2(WHOLE + 1);
    localparam logic [PW_W-1:0] PW_LOAD = PW_W'(WHOLE);

    logic [PW_W-1:0] pw_q;

    always_ff @(posedge clk) begin
        if (rst)
            pw_q <= '0;
        else if (start)
            pw_q <= PW_LOAD;
        else if (pw_q != '0)
            pw_q <= pw_q - PW_W'(1);
    end

    assign lvl_r = (pw_q != '0);

    // falling-edge copy adds the trailing half cycle
    always_ff @(negedge clk) begin
        if (rst)
            half_f <= 1'b0;
        else
            half_f <= lvl_r;
    end

    assign pulse = lvl_r | half_f;

endmodule

// File: rtl/rdiv_outmux.sv
module rdiv_outmux
    import rdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       out_en,
    input  rdiv_mode_e mode,
    input  logic       pulse,
    output logic       en_q,
    output logic       dout
);

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else
            en_q <= out_en;
    end

    always_comb begin
        unique case (mode)
            MODE_PASS:   dout = en_q & clk;
            default:     dout = en_q & pulse;
        endcase
    end

endmodule

// File: rtl/ref_divider.sv
module ref_divider
    import rdiv_pkg::*;
#(
    parameter int unsigned RATIO_W = RATIO_W_DEF
) (
    input  logic               clk_osc,
    input  logic               rst,
    input  logic [RATIO_W-1:0] div_ratio,
    input  logic               out_en,
    output logic               ref_out
);

    rdiv_tick_t tick;
    logic       tc_w;
    logic       start_w;
    logic       pass_w;
    logic       lvl_w;
    logic       half_w;
    logic       pulse_w;
    logic       en_w;

    rdiv_counter #(.RATIO_W(RATIO_W)) u_cnt (
        .clk   (clk_osc),
        .rst   (rst),
        .ratio (div_ratio),
        .tick  (tick)
    );

    assign tc_w    = tick.tc;
    assign start_w = tick.start;
    assign pass_w  = (tick.mode == MODE_PASS);

    rdiv_stretch #(.WHOLE(PULSE_WHOLE)) u_str (
        .clk    (clk_osc),
        .rst    (rst),
        .start  (start_w),
        .lvl_r  (lvl_w),
        .half_f (half_w),
        .pulse  (pulse_w)
    );

    rdiv_outmux u_mux (
        .clk    (clk_osc),
        .rst    (rst),
        .out_en (out_en),
        .mode   (tick.mode),
        .pulse  (pulse_w),
        .en_q   (en_w),
        .dout   (ref_out)
    );

endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker (
    input logic clk,
    input logic rst,
    input logic out_en,
    input logic ref_out,
    input logic tc,
    input logic start,
    input logic pass_mode,
    input logic lvl_r,
    input logic half_f
);

    AST_PULSE_AT_TC: assert property (@(posedge clk) disable iff (rst)
        start |=> lvl_r); // R2

    AST_PASS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (tc && !start) |=> pass_mode); // R4

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(lvl_r) |-> ($past(lvl_r, 4) && !$past(lvl_r, 5))); // R3

    AST_HALF_TRACK: assert property (@(posedge clk) disable iff (rst)
        half_f == lvl_r); // R3

    AST_PASS_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        pass_mode |-> (!lvl_r && !half_f)); // R4

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !$past(out_en) |-> !ref_out); // R7

endmodule

bind ref_divider rdiv_checker u_rdiv_chk (
    .clk       (clk_osc),
    .rst       (rst),
    .out_en    (out_en),
    .ref_out   (ref_out),
    .tc        (tc_w),
    .start     (start_w),
    .pass_mode (pass_w),
    .lvl_r     (lvl_w),
    .half_f    (half_w)
);

// File: tb/test_ref_divider.sv
`timescale 1ns/1ps
module test_ref_divider;

    localparam int W  = 16;
    localparam int NV = 8;
    // ratio, expected period in half-cycles, expected high half-cycles
    localparam int V_RATIO [NV] = '{6, 7, 10, 1, 3, 0, 100, 1000};
    localparam int V_PER   [NV] = '{12, 14, 20, 2, 12, 12, 200, 2000};
    localparam int V_HI    [NV] = '{9, 9, 9, 1, 9, 9, 9, 9};

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] ratio;
    logic         en;
    logic         dout;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ph     = 1'b0;
    logic prev_v = 1'b0;
    logic cur_v  = 1'b0;

    always #10 clk = ~clk;

    ref_divider #(.RATIO_W(W)) i_ref_divider (
        .clk_osc   (clk),
        .rst       (rst),
        .div_ratio (ratio),
        .out_en    (en),
        .ref_out   (dout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one sample in the middle of the next half-cycle
    task automatic next_sample();
        if (!ph) @(posedge clk); else @(negedge clk);
        #5;
        ph     = !ph;
        prev_v = cur_v;
        cur_v  = dout;
    endtask

    task automatic wait_rise(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            next_sample();
            if (!prev_v && cur_v) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    // starts on a rising sample, counts to the next one
    task automatic count_period(input int change_at, input int new_ratio,
                                output int per, output int hi);
        per = 1;
        hi  = 1;
        for (int i = 0; i < 6000; i++) begin
            if (i == change_at) ratio = W'(new_ratio);
            next_sample();
            if (!prev_v && cur_v) return;
            per++;
            hi += int'(cur_v);
        end
        per = -1;
    endtask

    initial begin
        #3000000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int  per, hi, highs;
        bit  ok;
        rst   = 1'b1;
        en    = 1'b1;
        ratio = W'(6);

        // R1: output low throughout reset
        highs = 0;
        for (int i = 0; i < 16; i++) begin
            next_sample();
            highs += int'(cur_v);
        end
        check(highs == 0, "R1 low in reset", highs, 0);

        // R1: enable cleared by reset, stays low while out_en is low
        en = 1'b0;
        next_sample();
        next_sample();
        rst = 1'b0;
        highs = 0;
        for (int i = 0; i < 40; i++) begin
            next_sample();
            highs += int'(cur_v);
        end
        check(highs == 0, "R1 low after reset until enabled", highs, 0);

        en = 1'b1;

        // table walk: R2/R3 periods and widths, R4 bypass, R5 clamp
        for (int v = 0; v < NV; v++) begin
            ratio = W'(V_RATIO[v]);
            wait_rise(ok);
            wait_rise(ok);
            wait_rise(ok);
            if (ok) count_period(-1, 0, per, hi);
            else begin per = -1; hi = -1; end
            if (V_RATIO[v] == 1) begin
                check(per == V_PER[v], "R4 pass-through period", per, V_PER[v]);
                check(hi == V_HI[v], "R4 pass-through high phase", hi, V_HI[v]);
            end else if (V_RATIO[v] < 6) begin
                check(per == V_PER[v], "R5 clamped period", per, V_PER[v]);
                check(hi == V_HI[v], "R5 clamped width", hi, V_HI[v]);
            end else begin
                check(per == V_PER[v], "R2 period", per, V_PER[v]);
                check(hi == V_HI[v], "R3 pulse width", hi, V_HI[v]);
            end
        end

        // R4: in pass-through the output is high exactly in the clock high phase
        ratio = W'(1);
        wait_rise(ok);
        wait_rise(ok);
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            next_sample();
            if (cur_v != (ph ? 1'b1 : 1'b0)) highs++;
        end
        check(highs == 0, "R4 follows clock phase", highs, 0);

        // R3: the pulse begins in the clock high phase right after a rising edge
        ratio = W'(8);
        wait_rise(ok);
        wait_rise(ok);
        check(ph == 1'b1, "R3 pulse starts at rising edge", int'(ph), 1);

        // R6: change mid-period, current period keeps the old ratio
        ratio = W'(10);
        wait_rise(ok);
        wait_rise(ok);
        count_period(4, 20, per, hi);
        check(per == 20, "R6 period not truncated", per, 20);
        count_period(-1, 0, per, hi);
        check(per == 40, "R6 new ratio at next terminal", per, 40);

        // R7: disabled in divide mode
        en = 1'b0;
        next_sample();
        next_sample();
        highs = 0;
        for (int i = 0; i < 100; i++) begin
            next_sample();
            highs += int'(cur_v);
        end
        check(highs == 0, "R7 disabled divide mode low", highs, 0);

        // R7: disabled in pass-through mode
        ratio = W'(1);
        highs = 0;
        for (int i = 0; i < 100; i++) begin
            next_sample();
            highs += int'(cur_v);
        end
        check(highs == 0, "R7 disabled pass-through low", highs, 0);

        // R7: re-enabled, output toggles again
        en = 1'b1;
        wait_rise(ok);
        check(ok, "R7 re-enable restores output", int'(ok), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule